// File: doc/BRIEF.md
# Single-Bus Microcoded Core with Atomic Fetch-and-Add

This block is a small processor datapath in which every transfer travels over one shared data bus. The instruction register, a register file, two ALU operand latches (A and B), the ALU, a memory-address latch and a word memory are the bus's only endpoints. A micro-sequencer steps through a computed microcode store. Each microinstruction says which single source drives the bus, which latches capture it, what the ALU does, whether memory is written, and how the next micro-state is chosen. The next-state choice is step, jump or dispatch on opcode.

The microprogram fetches an instruction and advances the PC by 4. It then dispatches either to a no-op or to an atomic fetch-and-add. Fetch-and-add reads the word addressed by register `rd`, stores that word plus register `rs` back to the same address, and leaves the original word in `rs`. A load port fills memory and registers while reset is held. A debug port reads one register and one memory word combinationally.

Micro-states and their codes on `upc_o`:
- Fetch: FETCH0 (0), FETCH1 (1), FETCH2 (2).
- No-op: NOP0 (3).
- Fetch-and-add: XADD0 (4), XADD1 (5), XADD2 (6), XADD3 (7).

Transitions:
- FETCH0 steps to FETCH1, and FETCH1 steps to FETCH2.
- FETCH2 dispatches to XADD0 or NOP0.
- XADD0 steps to XADD1, XADD1 to XADD2, and XADD2 to XADD3.
- XADD3 and NOP0 jump to FETCH0.

Top module: `xadd_ucore`

## Requirements
- R1: While `rst_n` is low, the micro-state is FETCH0 (code 0) and the PC is 0. Load-port writes (`ld_is_reg`=1 selects register `ld_addr[4:0]`, 0 selects the memory word at byte address `ld_addr`) take effect on each clock edge.
- R2: The fetch runs in three cycles. FETCH0 drives the PC on the bus into MA and A. FETCH1 drives memory[MA] on the bus into IR. FETCH2 drives A+4 on the bus into the PC.
- R3: Instruction fields are: opcode in bits 31:26, `rs` in bits 25:21, `rd` in bits 20:16. FETCH2 dispatches opcode 6'h01 to XADD0 and every other opcode to NOP0.
- R4: Each instruction ends by returning to FETCH0. A no-op takes 4 cycles and a fetch-and-add takes 7.
- R5: At most one bus source is enabled in any cycle. `drv_o` shows the enables as bit 3 immediate, bit 2 memory, bit 1 ALU, bit 0 register. A cycle with no source leaves the bus at 0.
- R6: Fetch-and-add with distinct `rs` and `rd` writes old+R[rs] (modulo 2^32) to the word at R[rd] and writes the old word into R[rs].
- R7: During any instruction, no register other than `rs` changes, `rd` included. The PC changes only by +4 at the end of FETCH2.
- R8: When `rs` equals `rd`, the register receives the old word and memory receives old plus the original address.
- R9: During fetch-and-add the bus carries, in order:
  - XADD0: R[rd];
  - XADD1: R[rs];
  - XADD2: the old memory word;
  - XADD3: the sum.
  The opcode held in IR is unchanged from the end of FETCH1 until the next FETCH1.
- R10: Memory is word addressed by byte-address bits [MEM_AW+1:2]. Higher address bits are ignored, so addresses alias modulo the memory size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of sequencer and control registers |
| ld_en | input | 1 | Load-port write strobe |
| ld_is_reg | input | 1 | 1: load a register, 0: load a memory word |
| ld_addr | input | MEM_AW+2 | Register index (low 5 bits) or byte address |
| ld_data | input | DATA_W | Load-port write data |
| dbg_addr | input | MEM_AW+2 | Debug read index / byte address |
| dbg_reg_data | output | DATA_W | Register at `dbg_addr[4:0]` |
| dbg_mem_data | output | DATA_W | Memory word at `dbg_addr` |
| upc_o | output | 3 | Current micro-state code |
| pc_o | output | DATA_W | Program counter |
| bus_o | output | DATA_W | Shared bus value this cycle |
| drv_o | output | 4 | Bus source enables {imm, mem, alu, reg} |

## Verification
The cycle that carries the most at once is XADD2. In that cycle one bus value, the old memory word, is written into register `rs` and also captured in latch A, while B still holds the earlier value of `rs`. The program provokes this with `rs` equal to `rd`, so the register that supplied the address is overwritten in the same cycle that its old value feeds the sum. The bench model judges the result by comparing every register, the PC and the touched memory word at each instruction boundary, and by checking the bus value and the micro-state on every clock.

// File: rtl/xadd_pkg.sv
package xadd_pkg;
    localparam int OPC_HI = 31;
    localparam int OPC_LO = 26;
    localparam int RS_HI  = 25;
    localparam int RS_LO  = 21;
    localparam int RD_HI  = 20;
    localparam int RD_LO  = 16;
    localparam int IMM_W  = 16;
    localparam int RF_AW  = RS_HI - RS_LO + 1;
    localparam int OPC_W  = OPC_HI - OPC_LO + 1;
    localparam logic [OPC_W-1:0] OPC_XADD = 6'h01;

    typedef enum logic [2:0] {
        U_FETCH0 = 3'd0, U_FETCH1 = 3'd1, U_FETCH2 = 3'd2, U_NOP0 = 3'd3,
        U_XADD0  = 3'd4, U_XADD1  = 3'd5, U_XADD2  = 3'd6, U_XADD3 = 3'd7
    } ustate_t;

    typedef enum logic [1:0] { SEL_PC, SEL_RS, SEL_RD } rsel_t;
    typedef enum logic [1:0] { ALU_COPY_A, ALU_INC4, ALU_ADD } aluop_t;
    typedef enum logic [1:0] { BR_NEXT, BR_JUMP, BR_DISP } ubr_t;

    typedef struct packed {
        logic   ld_ir;
        rsel_t  rsel;
        logic   reg_wr;
        logic   en_reg;
        logic   ld_a;
        logic   ld_b;
        aluop_t alu;
        logic   en_alu;
        logic   ld_ma;
        logic   mem_wr;
        logic   en_mem;
        logic   en_imm;
    } dctl_t;

    typedef struct packed {
        dctl_t   d;
        ubr_t    br;
        ustate_t tgt;
    } uinstr_t;
endpackage

// File: rtl/xadd_urom.sv
module xadd_urom
    import xadd_pkg::*;
(
    input  ustate_t st,
    output uinstr_t ui
);
    always_comb begin
        ui = '0;
        ui.br  = BR_NEXT;
        ui.tgt = U_FETCH0;
        unique case (st)
            U_FETCH0: begin
                ui.d.rsel = SEL_PC; ui.d.en_reg = 1'b1;
                ui.d.ld_ma = 1'b1;  ui.d.ld_a = 1'b1;
            end
            U_FETCH1: begin
                ui.d.en_mem = 1'b1; ui.d.ld_ir = 1'b1;
            end
            U_FETCH2: begin
                ui.d.alu = ALU_INC4; ui.d.en_alu = 1'b1;
                ui.d.rsel = SEL_PC;  ui.d.reg_wr = 1'b1;
                ui.br = BR_DISP;
            end
            U_NOP0: begin
                ui.br = BR_JUMP;
            end
            U_XADD0: begin
                ui.d.rsel = SEL_RD; ui.d.en_reg = 1'b1; ui.d.ld_ma = 1'b1;
            end
            U_XADD1: begin
                ui.d.rsel = SEL_RS; ui.d.en_reg = 1'b1; ui.d.ld_b = 1'b1;
            end
            U_XADD2: begin
                ui.d.en_mem = 1'b1; ui.d.ld_a = 1'b1;
                ui.d.rsel = SEL_RS; ui.d.reg_wr = 1'b1;
            end
            U_XADD3: begin
                ui.d.alu = ALU_ADD; ui.d.en_alu = 1'b1; ui.d.mem_wr = 1'b1;
                ui.br = BR_JUMP;
            end
        endcase
    end
endmodule

// File: rtl/xadd_useq.sv
module xadd_useq
    import xadd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ubr_t             br,
    input  ustate_t          tgt,
    input  logic [OPC_W-1:0] opcode,
    output ustate_t          st
);
    ustate_t nxt;

    always_comb begin
        unique case (br)
            BR_JUMP: nxt = tgt;
            BR_DISP: nxt = (opcode == OPC_XADD) ? U_XADD0 : U_NOP0;
            default: nxt = ustate_t'(st + 3'd1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= U_FETCH0;
        else        st <= nxt;
    end

    p_fetch_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == U_FETCH0) |=> (st == U_FETCH1));
    p_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == U_FETCH2) |=> (st == U_XADD0 || st == U_NOP0));
    p_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == U_XADD3 || st == U_NOP0) |=> (st == U_FETCH0));
endmodule

// File: rtl/xadd_dpath.sv
module xadd_dpath
    import xadd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dctl_t             c,
    input  logic              ld_en,
    input  logic              ld_is_reg,
    input  logic [MEM_AW+1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [MEM_AW+1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_reg_data,
    output logic [DATA_W-1:0] dbg_mem_data,
    output logic [OPC_W-1:0]  opcode,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] bus,
    output logic [3:0]        drv
);
    localparam int NREG  = 1 << RF_AW;
    localparam int NWORD = 1 << MEM_AW;

    logic [DATA_W-1:0] ir, a, b;
    logic [MEM_AW-1:0] ma;
    logic [DATA_W-1:0] rf  [NREG];
    logic [DATA_W-1:0] mem [NWORD];
    logic [RF_AW-1:0]  rs_idx, rd_idx;
    logic [DATA_W-1:0] reg_out, alu_out, mem_out, imm;

    assign rs_idx  = ir[RS_HI:RS_LO];
    assign rd_idx  = ir[RD_HI:RD_LO];
    assign opcode  = ir[OPC_HI:OPC_LO];
    assign imm     = {{(DATA_W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
    assign mem_out = mem[ma];

    always_comb begin
        unique case (c.rsel)
            SEL_RS:  reg_out = rf[rs_idx];
            SEL_RD:  reg_out = rf[rd_idx];
            default: reg_out = pc;
        endcase
    end

    always_comb begin
        unique case (c.alu)
            ALU_INC4: alu_out = a + DATA_W'(4);
            ALU_ADD:  alu_out = a + b;
            default:  alu_out = a;
        endcase
    end

    assign drv = {c.en_imm, c.en_mem, c.en_alu, c.en_reg};
    assign bus = ({DATA_W{c.en_reg}} & reg_out) | ({DATA_W{c.en_alu}} & alu_out)
               | ({DATA_W{c.en_mem}} & mem_out) | ({DATA_W{c.en_imm}} & imm);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir <= '0; a <= '0; b <= '0; ma <= '0; pc <= '0;
        end else begin
            if (c.ld_ir) ir <= bus;
            if (c.ld_a)  a  <= bus;
            if (c.ld_b)  b  <= bus;
            if (c.ld_ma) ma <= bus[MEM_AW+1:2];
            if (c.reg_wr && c.rsel == SEL_PC) pc <= bus;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_is_reg)
            rf[ld_addr[RF_AW-1:0]] <= ld_data;
        else if (c.reg_wr && c.rsel == SEL_RS)
            rf[rs_idx] <= bus;
        else if (c.reg_wr && c.rsel == SEL_RD)
            rf[rd_idx] <= bus;
    end

    always_ff @(posedge clk) begin
        if (ld_en && !ld_is_reg) mem[ld_addr[MEM_AW+1:2]] <= ld_data;
        else if (c.mem_wr)       mem[ma] <= bus;
    end

    assign dbg_reg_data = rf[dbg_addr[RF_AW-1:0]];
    assign dbg_mem_data = mem[dbg_addr[MEM_AW+1:2]];

    p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drv) <= 1);
endmodule

// File: rtl/xadd_ucore.sv
module xadd_ucore
    import xadd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_is_reg,
    input  logic [MEM_AW+1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [MEM_AW+1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_reg_data,
    output logic [DATA_W-1:0] dbg_mem_data,
    output logic [2:0]        upc_o,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] bus_o,
    output logic [3:0]        drv_o
);
    ustate_t          st;
    uinstr_t          ui;
    logic [OPC_W-1:0] opcode;

    xadd_urom u_rom (.st(st), .ui(ui));

    xadd_useq u_seq (
        .clk(clk), .rst_n(rst_n), .br(ui.br), .tgt(ui.tgt),
        .opcode(opcode), .st(st)
    );

    xadd_dpath #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_dp (
        .clk(clk), .rst_n(rst_n), .c(ui.d),
        .ld_en(ld_en), .ld_is_reg(ld_is_reg), .ld_addr(ld_addr), .ld_data(ld_data),
        .dbg_addr(dbg_addr), .dbg_reg_data(dbg_reg_data), .dbg_mem_data(dbg_mem_data),
        .opcode(opcode), .pc(pc_o), .bus(bus_o), .drv(drv_o)
    );

    assign upc_o = st;

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == U_FETCH2) |=> (pc_o == $past(pc_o) + DATA_W'(4)));
    p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != U_FETCH2) |=> $stable(pc_o));
    p_ir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != U_FETCH1) |=> $stable(opcode));
endmodule

// File: tb/xadd_ucore_tb.sv
`timescale 1ns/1ps
module xadd_ucore_tb;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int NINSTR = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0, ld_is_reg = 1'b0;
    logic [AW+1:0] ld_addr = '0, dbg_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [DW-1:0] dbg_reg_data, dbg_mem_data, pc_o, bus_o;
    logic [2:0]    upc_o;
    logic [3:0]    drv_o;

    xadd_ucore #(.DATA_W(DW), .MEM_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_is_reg(ld_is_reg),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_addr(dbg_addr),
        .dbg_reg_data(dbg_reg_data), .dbg_mem_data(dbg_mem_data),
        .upc_o(upc_o), .pc_o(pc_o), .bus_o(bus_o), .drv_o(drv_o)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [DW-1:0] mreg [32];
    logic [DW-1:0] mmem [1 << AW];
    logic [DW-1:0] mpc = '0;
    int            q_st[$];
    logic [DW-1:0] q_bus[$];
    logic [AW+1:0] touched = '0;
    string         mtag = "R6";

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] enc(int op, int rs, int rd);
        return {op[5:0], rs[4:0], rd[4:0], 16'h0};
    endfunction

    task automatic load(bit isreg, int addr, logic [DW-1:0] data);
        ld_en = 1'b1; ld_is_reg = isreg; ld_addr = addr[AW+1:0]; ld_data = data;
        if (isreg) mreg[addr[4:0]] = data;
        else       mmem[addr[AW+1:2]] = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic push(int s, logic [DW-1:0] v);
        q_st.push_back(s);
        q_bus.push_back(v);
    endtask

    task automatic build_instr();
        logic [DW-1:0] w, old, sum, addr;
        int op, rs, rd;
        w  = mmem[mpc[AW+1:2]];
        op = int'(w[31:26]); rs = int'(w[25:21]); rd = int'(w[20:16]);
        push(0, mpc); push(1, w); push(2, mpc + 4);
        if (op == 1) begin
            addr = mreg[rd];
            old  = mmem[addr[AW+1:2]];
            sum  = old + mreg[rs];
            push(4, mreg[rd]); push(5, mreg[rs]); push(6, old); push(7, sum);
            mreg[rs] = old;
            mmem[addr[AW+1:2]] = sum;
            touched = addr[AW+1:0];
            mtag = (rs == rd) ? "R8" : "R6";
        end else begin
            push(3, '0);
        end
        mpc = mpc + 4;
    endtask

    task automatic compare_arch();
        for (int i = 0; i < 32; i++) begin
            dbg_addr = i[AW+1:0];
            #0.01;
            chk("R7 register file", dbg_reg_data, mreg[i]);
        end
        chk("R7 pc", pc_o, mpc);
        dbg_addr = touched;
        #0.01;
        chk(mtag, dbg_mem_data, mmem[touched[AW+1:2]]);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int ninstr = 0;
        bit started = 0;
        int exp_st;
        logic [DW-1:0] exp_bus;
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        for (int i = 0; i < (1 << AW); i++) mmem[i] = '0;
        @(negedge clk);
        // R1: preload under reset
        for (int i = 0; i < 32; i++) load(1, i, '0);
        for (int i = 0; i < 16; i++) load(0, i * 4, '0);
        load(1, 1, 32'h100); load(1, 2, 32'h5);
        load(1, 3, 32'h104); load(1, 4, 32'hFFFF_FFFF);
        load(1, 5, 32'h504); load(1, 6, 32'h3);
        load(1, 7, 32'h108);
        load(0, 32'h100, 32'd10);
        load(0, 32'h104, 32'h7FFF_FFFF);
        load(0, 32'h108, 32'h22);
        load(0, 32'h00, enc(1, 2, 1));    // R6
        load(0, 32'h04, enc(0, 0, 0));    // R3 no-op
        load(0, 32'h08, enc(1, 4, 3));    // R6 wrap of sum
        load(0, 32'h0C, enc(63, 1, 2));   // R3 unknown opcode
        load(0, 32'h10, enc(1, 2, 1));    // R6 again, same word
        load(0, 32'h14, enc(1, 7, 7));    // R8
        load(0, 32'h18, enc(1, 6, 5));    // R10 alias of 0x104
        load(0, 32'h1C, enc(2, 3, 4));    // R3 unknown opcode
        #0.5;
        chk("R1 reset upc", {29'd0, upc_o}, 32'd0);
        chk("R1 reset pc", pc_o, 32'd0);
        dbg_addr = 10'h104; #0.01;
        chk("R1 load port memory", dbg_mem_data, 32'h7FFF_FFFF);
        @(negedge clk);
        rst_n = 1'b1;
        forever begin
            #0.5;
            if (q_st.size() == 0) begin
                if (started) compare_arch();
                if (ninstr == NINSTR) break;
                started = 1;
                build_instr();
                ninstr++;
            end
            exp_st  = q_st.pop_front();
            exp_bus = q_bus.pop_front();
            chk("R4 micro-state sequence (R2 R3)", {29'd0, upc_o}, exp_st);
            chk((exp_st >= 4) ? "R9 bus value" : "R2 bus value", bus_o, exp_bus);
            chk("R5 single bus driver", {31'd0, ($countones(drv_o) <= 1)}, 32'd1);
            @(negedge clk);
        end
        // R10: the alias write at 0x504 must land on the word at 0x104
        dbg_addr = 10'h104; #0.01;
        chk("R10 alias word", dbg_mem_data, 32'h8000_0001);
        // R8: register 7 holds the old word after rs==rd
        dbg_addr = 10'd7; #0.01;
        chk("R8 register", dbg_reg_data, 32'h22);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule